// File: doc/BRIEF.md
# Configuration Port Unlock and Banked Device Registers

This block holds the configuration space of a legacy peripheral controller that a host reaches over a byte-wide I/O bus through an index/data port pair. Host software writes a register number to the index port and then reads or writes the value through the data port next to it. The space stays closed until a two-byte key is written to the index port, and a single lock byte closes it again. While it is closed, the data port reads as a floating bus and ignores writes.

A small set of global registers sits in the space: a logical device number, the read-only identity bytes, and a port-select register. One bit of the port-select register moves the whole interface from the primary pair to the alternate pair. The logical device number selects one bank out of a parameterised number of per-device banks. Each bank holds an enable bit, a 16-bit I/O base address and a 4-bit interrupt line. These values go straight out to the peripherals. One device, the infrared receiver, also has a read-only class code that reports how many transmitters it has.

Top module: `sio_cfg_port`

## Requirements
- R1: Writing 0x87 to the active index port on two index-port writes in a row opens the configuration space. Writing 0xAA to the active index port while open closes it.
- R2: While closed, any read of the active pair returns 0xFF. Data-port writes change no register, and index-port writes other than the key do not change the stored index.
- R3: While the unlock is in progress, an index-port write of any byte other than 0x87 cancels the unlock. The next 0x87 then counts as the first key byte again.
- R4: While open, writing a value to the index port selects that register. The next data-port access reads or writes it. Register 0x07 is the logical device number and reads back the value last written.
- R5: Global registers 0x20, 0x21, 0x23, 0x24 read 0x04, 0x08, 0x19, 0x34, and writes to them are ignored. Register 0x25 reads 0x01 with its bit 4 clear.
- R6: Bit 4 of register 0x25 picks the active pair: 0 means index 0x2E and data 0x2F, and 1 means index 0x4E and data 0x4F. The open or closed state carries across the switch. The inactive pair reads 0xFF, and key bytes written to it have no effect.
- R7: For the device named by register 0x07: register 0x30 bit 0 is its enable, 0x60 and 0x61 are the high and low bytes of its base address, and 0x70 bits 3..0 are its interrupt line (upper bits read 0). These values drive that device's outputs, and the other banks stay unchanged.
- R8: When device 5 (infrared) is selected, register 0xF0 reads the class code parameter (default 0x66, meaning receive plus two transmitters). For other devices it reads 0x00.
- R9: After reset the space is closed, the logical device number is 0, and every device output has enable 0, base 0 and interrupt 0.
- R10: A read of the active index port while open returns the stored index. A read of any address outside the active pair returns 0xFF. Read data appears on the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | ADDR_W | Host I/O address |
| ioWrData | input | 8 | Host write byte |
| ioWr | input | 1 | Host write strobe, one cycle per access |
| ioRd | input | 1 | Host read strobe, one cycle per access |
| ioRdData | output | 8 | Read byte, valid the cycle after ioRd |
| devEnable | output | NUM_DEV | Per-device enable |
| devBase | output | NUM_DEV x 16 | Per-device I/O base address |
| devIrq | output | NUM_DEV x IRQ_W | Per-device interrupt line |

## Verification
The unlock logic gets a clean double key, a key broken by a stray byte and then completed, and key bytes sent to the inactive pair. Together these separate a correct two-step sequence from a single-byte unlock, from a sequence that is never cancelled, and from a decoder that ignores the port select. The banked registers are written under one device number and read back under another. This shows that the outputs of one device do not leak into the bank of another. Writes made while closed are checked at the device outputs and through the stored index after reopening, so a write path that leaks through the lock is caught.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam logic [7:0] KEY_OPEN  = 8'h87;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;

  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_CHIP_HI = 8'h20;
  localparam logic [7:0] IDX_CHIP_LO = 8'h21;
  localparam logic [7:0] IDX_VEND_HI = 8'h23;
  localparam logic [7:0] IDX_VEND_LO = 8'h24;
  localparam logic [7:0] IDX_PORTSEL = 8'h25;
  localparam logic [7:0] IDX_ENABLE  = 8'h30;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;
  localparam logic [7:0] IDX_IRQ     = 8'h70;
  localparam logic [7:0] IDX_CLASS   = 8'hF0;

  localparam int PORTSEL_BIT = 4;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_KEY1   = 2'd1,
    ST_OPEN   = 2'd2
  } unlockState_e;

  typedef enum logic [1:0] {
    RD_FLOAT = 2'd0,
    RD_INDEX = 2'd1,
    RD_DATA  = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic       cfgWr;
    logic       rdEn;
    rdSel_e     rdSel;
    logic [7:0] index;
    logic [7:0] wrData;
  } cfgStrobe_t;
endpackage

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
  import sio_cfg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PRI_IDX = 16'h002E,
  parameter logic [ADDR_W-1:0] ALT_IDX = 16'h004E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [7:0]        ioWrData,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic              altPortSel,
  output cfgStrobe_t        strobe,
  output logic              unlocked
);
  unlockState_e      state, stateNext;
  logic [7:0]        indexReg;
  logic [ADDR_W-1:0] idxAddr;
  logic [ADDR_W-1:0] dataAddr;
  logic              hitIdx, hitData, idxWr;

  assign idxAddr  = altPortSel ? ALT_IDX : PRI_IDX;
  assign dataAddr = idxAddr + ADDR_W'(1);
  assign hitIdx   = (ioAddr == idxAddr);
  assign hitData  = (ioAddr == dataAddr);
  assign idxWr    = ioWr && hitIdx;

  always_comb begin
    stateNext = state;
    if (idxWr) begin
      unique case (state)
        ST_LOCKED: stateNext = (ioWrData == KEY_OPEN) ? ST_KEY1 : ST_LOCKED;
        ST_KEY1:   stateNext = (ioWrData == KEY_OPEN) ? ST_OPEN : ST_LOCKED;
        ST_OPEN:   stateNext = (ioWrData == KEY_CLOSE) ? ST_LOCKED : ST_OPEN;
        default:   stateNext = ST_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_LOCKED;
      indexReg <= 8'h00;
    end else begin
      state <= stateNext;
      if (idxWr && state == ST_OPEN && ioWrData != KEY_CLOSE)
        indexReg <= ioWrData;
    end
  end

  assign unlocked = (state == ST_OPEN);

  always_comb begin
    strobe.cfgWr  = ioWr && hitData && unlocked;
    strobe.rdEn   = ioRd;
    strobe.index  = indexReg;
    strobe.wrData = ioWrData;
    if (unlocked && hitData)     strobe.rdSel = RD_DATA;
    else if (unlocked && hitIdx) strobe.rdSel = RD_INDEX;
    else                         strobe.rdSel = RD_FLOAT;
  end
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter int IRQ_W = 4,
  parameter int IR_DEV = 5,
  parameter logic [7:0] IR_CLASS = 8'h66,
  parameter logic [15:0] CHIP_ID = 16'h0408,
  parameter logic [15:0] VENDOR_ID = 16'h1934,
  parameter logic [7:0] PORTSEL_FIXED = 8'h01
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  cfgStrobe_t                        strobe,
  output logic [7:0]                        ioRdData,
  output logic                              altPortSel,
  output logic [NUM_DEV-1:0]                devEnable,
  output logic [NUM_DEV-1:0][15:0]          devBase,
  output logic [NUM_DEV-1:0][IRQ_W-1:0]     devIrq
);
  localparam int LDN_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam logic [7:0] NUM_DEV_B = 8'(NUM_DEV);

  logic [7:0]       ldn;
  logic             ldnValid;
  logic [LDN_W-1:0] ldnIdx;
  logic [7:0]       bankRd, globalRd, cfgRd, rdVal;
  logic             isBankIdx;

  assign ldnValid = (ldn < NUM_DEV_B);
  assign ldnIdx   = ldn[LDN_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldn        <= 8'h00;
      altPortSel <= 1'b0;
    end else if (strobe.cfgWr) begin
      if (strobe.index == IDX_LDN)     ldn <= strobe.wrData;
      if (strobe.index == IDX_PORTSEL) altPortSel <= strobe.wrData[PORTSEL_BIT];
    end
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : gBank
    logic bankWr;
    assign bankWr = strobe.cfgWr && (ldn == 8'(g));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        devEnable[g] <= 1'b0;
        devBase[g]   <= 16'h0000;
        devIrq[g]    <= '0;
      end else if (bankWr) begin
        unique case (strobe.index)
          IDX_ENABLE:  devEnable[g]     <= strobe.wrData[0];
          IDX_BASE_HI: devBase[g][15:8] <= strobe.wrData;
          IDX_BASE_LO: devBase[g][7:0]  <= strobe.wrData;
          IDX_IRQ:     devIrq[g]        <= strobe.wrData[IRQ_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    isBankIdx = 1'b1;
    bankRd    = 8'h00;
    unique case (strobe.index)
      IDX_ENABLE:  bankRd = {7'b0, devEnable[ldnIdx]};
      IDX_BASE_HI: bankRd = devBase[ldnIdx][15:8];
      IDX_BASE_LO: bankRd = devBase[ldnIdx][7:0];
      IDX_IRQ:     bankRd = 8'(devIrq[ldnIdx]);
      IDX_CLASS:   bankRd = (ldn == 8'(IR_DEV)) ? IR_CLASS : 8'h00;
      default:     isBankIdx = 1'b0;
    endcase
    if (!ldnValid) bankRd = 8'h00;
  end

  always_comb begin
    unique case (strobe.index)
      IDX_LDN:     globalRd = ldn;
      IDX_CHIP_HI: globalRd = CHIP_ID[15:8];
      IDX_CHIP_LO: globalRd = CHIP_ID[7:0];
      IDX_VEND_HI: globalRd = VENDOR_ID[15:8];
      IDX_VEND_LO: globalRd = VENDOR_ID[7:0];
      IDX_PORTSEL: begin
        globalRd = PORTSEL_FIXED;
        globalRd[PORTSEL_BIT] = altPortSel;
      end
      default:     globalRd = 8'h00;
    endcase
  end

  assign cfgRd = isBankIdx ? bankRd : globalRd;

  always_comb begin
    unique case (strobe.rdSel)
      RD_DATA:  rdVal = cfgRd;
      RD_INDEX: rdVal = strobe.index;
      default:  rdVal = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            ioRdData <= 8'hFF;
    else if (strobe.rdEn) ioRdData <= rdVal;
  end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NUM_DEV = 8,
  parameter int IRQ_W = 4,
  parameter int IR_DEV = 5,
  parameter logic [7:0] IR_CLASS = 8'h66,
  parameter logic [ADDR_W-1:0] PRI_IDX = 16'h002E,
  parameter logic [ADDR_W-1:0] ALT_IDX = 16'h004E
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             ioAddr,
  input  logic [7:0]                    ioWrData,
  input  logic                          ioWr,
  input  logic                          ioRd,
  output logic [7:0]                    ioRdData,
  output logic [NUM_DEV-1:0]            devEnable,
  output logic [NUM_DEV-1:0][15:0]      devBase,
  output logic [NUM_DEV-1:0][IRQ_W-1:0] devIrq
);
  cfgStrobe_t strobe;
  logic       unlocked;
  logic       altPortSel;

  sio_cfg_ctrl #(
    .ADDR_W(ADDR_W), .PRI_IDX(PRI_IDX), .ALT_IDX(ALT_IDX)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrData(ioWrData),
    .ioWr(ioWr), .ioRd(ioRd), .altPortSel(altPortSel),
    .strobe(strobe), .unlocked(unlocked)
  );

  sio_cfg_regs #(
    .NUM_DEV(NUM_DEV), .IRQ_W(IRQ_W), .IR_DEV(IR_DEV), .IR_CLASS(IR_CLASS)
  ) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ioRdData(ioRdData),
    .altPortSel(altPortSel), .devEnable(devEnable), .devBase(devBase),
    .devIrq(devIrq)
  );
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int ADDR_W = 16,
  parameter int NUM_DEV = 8,
  parameter int IRQ_W = 4,
  parameter logic [ADDR_W-1:0] PRI_IDX = 16'h002E,
  parameter logic [ADDR_W-1:0] ALT_IDX = 16'h004E
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [ADDR_W-1:0]             ioAddr,
  input logic [7:0]                    ioWrData,
  input logic                          ioWr,
  input logic                          ioRd,
  input logic [7:0]                    ioRdData,
  input logic                          unlocked,
  input logic                          altPortSel,
  input logic [NUM_DEV-1:0]            devEnable,
  input logic [NUM_DEV-1:0][15:0]      devBase,
  input logic [NUM_DEV-1:0][IRQ_W-1:0] devIrq
);
  logic [ADDR_W-1:0] activeIdx;
  assign activeIdx = altPortSel ? ALT_IDX : PRI_IDX;

  AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> $past(ioWr && ioWrData == 8'h87)); // R1

  AST_CLOSE_ON_KEY: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && ioWr && ioAddr == activeIdx && ioWrData == 8'hAA) |=> !unlocked); // R1

  AST_LOCKED_READ_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && !unlocked) |=> ioRdData == 8'hFF); // R2

  AST_LOCKED_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |=> ($stable(devEnable) && $stable(devBase) && $stable(devIrq))); // R2

  AST_LOCKED_PORTSEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |=> $stable(altPortSel)); // R6
endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .ADDR_W(ADDR_W), .NUM_DEV(NUM_DEV), .IRQ_W(IRQ_W),
  .PRI_IDX(PRI_IDX), .ALT_IDX(ALT_IDX)
) uChk (
  .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrData(ioWrData),
  .ioWr(ioWr), .ioRd(ioRd), .ioRdData(ioRdData), .unlocked(unlocked),
  .altPortSel(altPortSel), .devEnable(devEnable), .devBase(devBase),
  .devIrq(devIrq)
);

// File: tb/sio_cfg_port_test.sv
module sio_cfg_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_DEV = 8;
  localparam int IRQ_W = 4;
  localparam int ADDR_W = 16;

  logic                          clk = 1'b0;
  logic                          rstN = 1'b0;
  logic [ADDR_W-1:0]             ioAddr = '0;
  logic [7:0]                    ioWrData = '0;
  logic                          ioWr = 1'b0;
  logic                          ioRd = 1'b0;
  logic [7:0]                    ioRdData;
  logic [NUM_DEV-1:0]            devEnable;
  logic [NUM_DEV-1:0][15:0]      devBase;
  logic [NUM_DEV-1:0][IRQ_W-1:0] devIrq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  sio_cfg_port uut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrData(ioWrData),
    .ioWr(ioWr), .ioRd(ioRd), .ioRdData(ioRdData), .devEnable(devEnable),
    .devBase(devBase), .devIrq(devIrq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Entry: {req[3:0], isRead[1:0], addr[15:0], wrData[7:0], expect[7:0]}
  localparam int NVEC = 37;
  localparam logic [37:0] VEC [NVEC] = '{
    {4'd1, 2'd0, 16'h002E, 8'h87, 8'h00},  // R1 first key
    {4'd1, 2'd0, 16'h002E, 8'h87, 8'h00},  // R1 second key
    {4'd9, 2'd0, 16'h002E, 8'h07, 8'h00},
    {4'd9, 2'd1, 16'h002F, 8'h00, 8'h00},  // R9 device number resets to 0
    {4'd5, 2'd0, 16'h002E, 8'h20, 8'h00},
    {4'd5, 2'd1, 16'h002F, 8'h00, 8'h04},  // R5 identity bytes
    {4'd5, 2'd0, 16'h002E, 8'h21, 8'h00},
    {4'd5, 2'd1, 16'h002F, 8'h00, 8'h08},
    {4'd5, 2'd0, 16'h002E, 8'h23, 8'h00},
    {4'd5, 2'd1, 16'h002F, 8'h00, 8'h19},
    {4'd5, 2'd0, 16'h002E, 8'h24, 8'h00},
    {4'd5, 2'd1, 16'h002F, 8'h00, 8'h34},
    {4'd5, 2'd0, 16'h002E, 8'h25, 8'h00},
    {4'd5, 2'd1, 16'h002F, 8'h00, 8'h01},
    {4'd4, 2'd0, 16'h002E, 8'h07, 8'h00},  // R4 select device 5
    {4'd4, 2'd0, 16'h002F, 8'h05, 8'h00},
    {4'd4, 2'd1, 16'h002F, 8'h00, 8'h05},
    {4'd10, 2'd1, 16'h002E, 8'h00, 8'h07}, // R10 index read back
    {4'd7, 2'd0, 16'h002E, 8'h30, 8'h00},  // R7 bank registers
    {4'd7, 2'd0, 16'h002F, 8'h01, 8'h00},
    {4'd7, 2'd1, 16'h002F, 8'h00, 8'h01},
    {4'd7, 2'd0, 16'h002E, 8'h60, 8'h00},
    {4'd7, 2'd0, 16'h002F, 8'h12, 8'h00},
    {4'd7, 2'd1, 16'h002F, 8'h00, 8'h12},
    {4'd7, 2'd0, 16'h002E, 8'h61, 8'h00},
    {4'd7, 2'd0, 16'h002F, 8'h34, 8'h00},
    {4'd7, 2'd1, 16'h002F, 8'h00, 8'h34},
    {4'd7, 2'd0, 16'h002E, 8'h70, 8'h00},
    {4'd7, 2'd0, 16'h002F, 8'h1A, 8'h00},
    {4'd7, 2'd1, 16'h002F, 8'h00, 8'h0A},
    {4'd8, 2'd0, 16'h002E, 8'hF0, 8'h00},  // R8 class of device 5
    {4'd8, 2'd1, 16'h002F, 8'h00, 8'h66},
    {4'd5, 2'd0, 16'h002E, 8'h20, 8'h00},  // R5 write to read-only
    {4'd5, 2'd0, 16'h002F, 8'h55, 8'h00},
    {4'd5, 2'd1, 16'h002F, 8'h00, 8'h04},
    {4'd10, 2'd1, 16'h0080, 8'h00, 8'hFF}, // R10 unrelated address
    {4'd10, 2'd1, 16'h004F, 8'h00, 8'hFF}  // R10 inactive pair
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic ioWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic ioRead(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioRd = 1'b1;
    @(negedge clk);
    ioRd = 1'b0;
    d = ioRdData;
  endtask

  task automatic readCheck(input string req, input logic [15:0] a, input logic [7:0] e);
    logic [7:0] v;
    ioRead(a, v);
    check(req, int'(v), int'(e));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finishRun();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state at the outputs
    check("R9 enable", int'(devEnable), 0);
    check("R9 base", int'(devBase), 0);
    check("R9 irq", int'(devIrq), 0);
    readCheck("R9 locked at reset", 16'h002F, 8'hFF);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][33:32] == 2'd0) begin
        ioWrite(VEC[i][31:16], VEC[i][15:8]);
      end else begin
        ioRead(VEC[i][31:16], v);
        check($sformatf("R%0d vector %0d", VEC[i][37:34], i), int'(v), int'(VEC[i][7:0]));
      end
    end

    // R7 values reach the device outputs, others untouched
    check("R7 dev5 enable", int'(devEnable), 32'h20);
    check("R7 dev5 base", int'(devBase[5]), 32'h1234);
    check("R7 dev5 irq", int'(devIrq[5]), 32'hA);
    check("R7 dev2 base", int'(devBase[2]), 0);

    ioWrite(16'h002E, 8'h07); ioWrite(16'h002F, 8'h02);
    ioWrite(16'h002E, 8'hF0);
    readCheck("R8 class on other device", 16'h002F, 8'h00);
    ioWrite(16'h002E, 8'h30);
    readCheck("R7 bank of device 2", 16'h002F, 8'h00);

    // R1 close, R2 locked behaviour
    ioWrite(16'h002E, 8'hAA);
    readCheck("R2 locked data read", 16'h002F, 8'hFF);
    readCheck("R2 locked index read", 16'h002E, 8'hFF);
    ioWrite(16'h002F, 8'h01);
    check("R2 locked write ignored", int'(devEnable), 32'h20);
    ioWrite(16'h002E, 8'h07);

    // R3 broken key sequence
    ioWrite(16'h002E, 8'h87); ioWrite(16'h002E, 8'h55); ioWrite(16'h002E, 8'h87);
    readCheck("R3 broken key stays locked", 16'h002F, 8'hFF);
    ioWrite(16'h002E, 8'h87);
    readCheck("R3 key completes", 16'h002F, 8'h00);
    readCheck("R2 index unchanged while locked", 16'h002E, 8'h30);

    // R6 alternate pair
    ioWrite(16'h002E, 8'h25); ioWrite(16'h002F, 8'h10);
    readCheck("R6 old pair floats", 16'h002F, 8'hFF);
    readCheck("R6 index at new pair", 16'h004E, 8'h25);
    readCheck("R6 port select value", 16'h004F, 8'h11);
    ioWrite(16'h004E, 8'hAA);
    readCheck("R6 lock at new pair", 16'h004F, 8'hFF);
    ioWrite(16'h002E, 8'h87); ioWrite(16'h002E, 8'h87);
    readCheck("R6 key at inactive pair ignored", 16'h004F, 8'hFF);
    ioWrite(16'h004E, 8'h87); ioWrite(16'h004E, 8'h87);
    readCheck("R6 unlock at new pair", 16'h004F, 8'h11);

    finishRun();
  end
endmodule